// File: doc/BRIEF.md
# Multicycle RISC instruction sequencer

This block is the control state machine for an unpipelined, multicycle datapath that runs a small 32-bit load/store instruction set. It looks at the word held in the datapath's instruction register and at a single condition flag that the datapath derives from operand A (asserted when A equals zero). From these it drives the register-transfer control points: instruction register load, PC load with a source select, A/B operand loads, ALU function and second-operand select, ALU result register load, memory read and write strobes, the WB register load with its source select, and the register-file write with its address and data select.

Every instruction starts with a shared fetch step, in which the instruction register is loaded from memory at PC and PC advances by 4, and a shared decode step, in which A and B are read from the rs and rt fields. The state graph then forks into a separate register-transfer sequence for each class: register-register, register-immediate, load, store, branch on zero, branch on non-zero, jump, jump-and-link, and jump through register. All control outputs come from flops, so each control word is the one of the state currently held. Register storage, the ALU and the memories live in the datapath; the datapath forms PC+immediate from the already-incremented PC, and it sign-extends immediates.

Top module: `mcyc_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the control word is the fetch word: ir_ld=1, pc_ld=1, pc_sel=0 (PC+4). All other outputs are 0.
- R2: Each instruction takes one fetch cycle (the fetch word) and then one decode cycle, in which only a_ld and b_ld are 1. After the last step of its class sequence, the next cycle is a fetch cycle.
- R3: Opcode 0x00 (bits 31:26) is register-register. The execute cycle has r_ld=1, alu_op=instr[2:0] and alu_bsel=0 (B). The next cycle has wb_ld=1 with wb_sel=0 (ALU result). The cycle after that has rf_we=1, rf_waddr=instr[15:11] and rf_dsel=0 (WB).
- R4: Opcodes 0x08 to 0x0F are register-immediate. They follow the sequence of R3, except that alu_op=opcode[2:0], alu_bsel=1 (immediate) and rf_waddr=instr[20:16].
- R5: Opcode 0x23 is a load. The address cycle has r_ld=1, alu_op=0 (add) and alu_bsel=1. Next comes mem_rd=1 with wb_ld=1 and wb_sel=1 (memory). Then comes a register write to instr[20:16] with rf_dsel=0.
- R6: Opcode 0x2B is a store. It has the address cycle of R5, then a cycle with mem_wr=1 only, then fetch. It never asserts rf_we.
- R7: Opcode 0x04 (branch if zero) and opcode 0x05 (branch if non-zero) have a test cycle with every control at 0, during which cond is sampled. A branch is taken when cond=1 for 0x04, or when cond=0 for 0x05. A taken branch adds a cycle with pc_ld=1 and pc_sel=1 (PC+immediate). An untaken branch goes straight to fetch.
- R8: Opcode 0x02 is a jump: one cycle with pc_ld=1 and pc_sel=2 (jump field, bits 25:0).
- R9: Opcode 0x03 is jump-and-link. A link cycle with rf_we=1, rf_waddr=LINK_REG and rf_dsel=1 (PC) comes first, followed by the jump cycle of R8.
- R10: Opcode 0x06 is a jump through register: one cycle with pc_ld=1 and pc_sel=3 (A).
- R11: A register write whose destination is register 0 is discarded: in that cycle rf_we=0 and rf_waddr=0.
- R12: Any other opcode returns to fetch directly after decode.
- R13: mem_rd and mem_wr are never 1 together. pc_sel, alu_op, alu_bsel, wb_sel, rf_waddr and rf_dsel are 0 in any cycle where their load or strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | IW | Current instruction register contents |
| cond | input | 1 | Datapath flag: operand A equals zero |
| ir_ld | output | 1 | Load instruction register from memory at PC |
| pc_ld | output | 1 | Load PC |
| pc_sel | output | 2 | PC source: 0 PC+4, 1 PC+imm, 2 jump field, 3 A |
| a_ld | output | 1 | Load A from register rs |
| b_ld | output | 1 | Load B from register rt |
| alu_op | output | 3 | ALU function: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 slt, 6 sll, 7 srl |
| alu_bsel | output | 1 | ALU second operand: 0 B, 1 immediate |
| r_ld | output | 1 | Load ALU result register r |
| mem_rd | output | 1 | Data memory read at r |
| mem_wr | output | 1 | Data memory write of B at r |
| wb_ld | output | 1 | Load WB register |
| wb_sel | output | 1 | WB source: 0 r, 1 memory data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RAW | Register file write address |
| rf_dsel | output | 1 | Register file write data: 0 WB, 1 PC |

## Verification
The bench builds the block with IW=32 and RAW=5, and overrides LINK_REG to 30. A link write landing on register 30 shows that the link index comes from the parameter and not from a hard-wired 31. Register 31 is then free to appear as an ordinary register-register destination. With 5-bit addresses, a destination of 0 can be placed in both the register-register and register-immediate formats, so the discard rule is exercised in both. Both branch polarities are run with cond at each value, so the taken path and the untaken path of each are compared cycle by cycle.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXRR, S_EXRI, S_ADDR, S_MRD, S_MWR,
    S_WBALU, S_WRITE, S_BTEST, S_BTAKE, S_JUMP, S_LINK, S_JREG
  } state_t;

  typedef enum logic [3:0] {
    C_RR, C_RI, C_LD, C_ST, C_BZ, C_BNZ, C_J, C_JSR, C_JR, C_BAD
  } iclass_t;

  typedef struct packed {
    logic       ir_ld;
    logic       pc_ld;
    logic [1:0] pc_sel;
    logic       a_ld;
    logic       b_ld;
    logic [2:0] alu_op;
    logic       alu_bsel;
    logic       r_ld;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_ld;
    logic       wb_sel;
    logic       rf_we;
    logic       rf_dsel;
  } ctrl_t;

  localparam logic [5:0] OP_RR  = 6'h00;
  localparam logic [5:0] OP_J   = 6'h02;
  localparam logic [5:0] OP_JSR = 6'h03;
  localparam logic [5:0] OP_BZ  = 6'h04;
  localparam logic [5:0] OP_BNZ = 6'h05;
  localparam logic [5:0] OP_JR  = 6'h06;
  localparam logic [5:0] OP_LD  = 6'h23;
  localparam logic [5:0] OP_ST  = 6'h2B;
  localparam logic [2:0] RI_GRP = 3'b001;

  localparam logic [1:0] PCS_INC = 2'd0;
  localparam logic [1:0] PCS_REL = 2'd1;
  localparam logic [1:0] PCS_JMP = 2'd2;
  localparam logic [1:0] PCS_REG = 2'd3;

  localparam logic [2:0] ALU_ADD = 3'd0;

  localparam ctrl_t CTRL_IDLE  = '0;
  localparam ctrl_t CTRL_FETCH = '{ir_ld: 1'b1, pc_ld: 1'b1, default: '0};

endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
#(
  parameter int IW       = 32,
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input  logic [IW-1:0]  instr,
  output iclass_t        iclass,
  output logic [2:0]     alu_fn,
  output logic [RAW-1:0] dest
);
  localparam int OPC_LO = IW - 6;
  localparam int RS_HI  = OPC_LO - 1;
  localparam int RT_HI  = RS_HI - RAW;
  localparam int RD_HI  = RT_HI - RAW;
  localparam int RD_LO  = RD_HI - RAW + 1;

  logic [5:0]     opc;
  logic [RAW-1:0] rt_f;
  logic [RAW-1:0] rd_f;
  logic           unused_bits;

  assign opc  = instr[IW-1:OPC_LO];
  assign rt_f = instr[RT_HI -: RAW];
  assign rd_f = instr[RD_HI -: RAW];
  assign unused_bits = ^{instr[RS_HI -: RAW], instr[RD_LO-1:3]};

  always_comb begin
    unique case (opc)
      OP_RR:   iclass = C_RR;
      OP_J:    iclass = C_J;
      OP_JSR:  iclass = C_JSR;
      OP_BZ:   iclass = C_BZ;
      OP_BNZ:  iclass = C_BNZ;
      OP_JR:   iclass = C_JR;
      OP_LD:   iclass = C_LD;
      OP_ST:   iclass = C_ST;
      default: iclass = (opc[5:3] == RI_GRP) ? C_RI : C_BAD;
    endcase
  end

  always_comb begin
    alu_fn = ALU_ADD;
    dest   = '0;
    case (iclass)
      C_RR:       begin alu_fn = instr[2:0]; dest = rd_f; end
      C_RI:       begin alu_fn = opc[2:0];   dest = rt_f; end
      C_LD:       dest = rt_f;
      C_JSR:      dest = RAW'(LINK_REG);
      default:    ;
    endcase
  end
endmodule

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
(
  input  state_t  state,
  input  iclass_t iclass,
  input  logic    cond,
  output state_t  nstate
);
  logic taken;

  assign taken = (iclass == C_BZ) ? cond : !cond;

  always_comb begin
    nstate = S_FETCH;
    case (state)
      S_FETCH:  nstate = S_DECODE;
      S_DECODE: begin
        case (iclass)
          C_RR:        nstate = S_EXRR;
          C_RI:        nstate = S_EXRI;
          C_LD, C_ST:  nstate = S_ADDR;
          C_BZ, C_BNZ: nstate = S_BTEST;
          C_J:         nstate = S_JUMP;
          C_JSR:       nstate = S_LINK;
          C_JR:        nstate = S_JREG;
          default:     nstate = S_FETCH;
        endcase
      end
      S_EXRR, S_EXRI: nstate = S_WBALU;
      S_ADDR:   nstate = (iclass == C_LD) ? S_MRD : S_MWR;
      S_MRD:    nstate = S_WRITE;
      S_WBALU:  nstate = S_WRITE;
      S_BTEST:  nstate = taken ? S_BTAKE : S_FETCH;
      S_LINK:   nstate = S_JUMP;
      default:  nstate = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_enc.sv
module mcyc_enc
  import mcyc_pkg::*;
#(
  parameter int RAW     = 5,
  parameter bit ZERO_R0 = 1'b1
) (
  input  state_t         nstate,
  input  logic [2:0]     alu_fn,
  input  logic [RAW-1:0] dest,
  output ctrl_t          ctrl,
  output logic [RAW-1:0] waddr
);
  logic dest_ok;

  generate
    if (ZERO_R0) begin : g_r0_hard
      assign dest_ok = (dest != '0);
    end else begin : g_r0_soft
      assign dest_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    ctrl  = CTRL_IDLE;
    waddr = '0;
    case (nstate)
      S_FETCH:  ctrl = CTRL_FETCH;
      S_DECODE: begin ctrl.a_ld = 1'b1; ctrl.b_ld = 1'b1; end
      S_EXRR:   begin ctrl.r_ld = 1'b1; ctrl.alu_op = alu_fn; end
      S_EXRI:   begin ctrl.r_ld = 1'b1; ctrl.alu_op = alu_fn; ctrl.alu_bsel = 1'b1; end
      S_ADDR:   begin ctrl.r_ld = 1'b1; ctrl.alu_op = ALU_ADD; ctrl.alu_bsel = 1'b1; end
      S_MRD:    begin ctrl.mem_rd = 1'b1; ctrl.wb_ld = 1'b1; ctrl.wb_sel = 1'b1; end
      S_MWR:    ctrl.mem_wr = 1'b1;
      S_WBALU:  ctrl.wb_ld = 1'b1;
      S_WRITE: begin
        ctrl.rf_we = dest_ok;
        waddr      = dest_ok ? dest : '0;
      end
      S_LINK: begin
        ctrl.rf_we   = dest_ok;
        ctrl.rf_dsel = dest_ok;
        waddr        = dest_ok ? dest : '0;
      end
      S_BTAKE:  begin ctrl.pc_ld = 1'b1; ctrl.pc_sel = PCS_REL; end
      S_JUMP:   begin ctrl.pc_ld = 1'b1; ctrl.pc_sel = PCS_JMP; end
      S_JREG:   begin ctrl.pc_ld = 1'b1; ctrl.pc_sel = PCS_REG; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
#(
  parameter int IW       = 32,
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  instr,
  input  logic           cond,
  output logic           ir_ld,
  output logic           pc_ld,
  output logic [1:0]     pc_sel,
  output logic           a_ld,
  output logic           b_ld,
  output logic [2:0]     alu_op,
  output logic           alu_bsel,
  output logic           r_ld,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           wb_ld,
  output logic           wb_sel,
  output logic           rf_we,
  output logic [RAW-1:0] rf_waddr,
  output logic           rf_dsel
);
  state_t         state_q, state_n;
  iclass_t        iclass;
  logic [2:0]     alu_fn;
  logic [RAW-1:0] dest;
  ctrl_t          ctrl_n, ctrl_q;
  logic [RAW-1:0] waddr_n, waddr_q;

  mcyc_decode #(.IW(IW), .RAW(RAW), .LINK_REG(LINK_REG)) u_dec (
    .instr  (instr),
    .iclass (iclass),
    .alu_fn (alu_fn),
    .dest   (dest)
  );

  mcyc_next u_nxt (
    .state  (state_q),
    .iclass (iclass),
    .cond   (cond),
    .nstate (state_n)
  );

  mcyc_enc #(.RAW(RAW), .ZERO_R0(1'b1)) u_enc (
    .nstate (state_n),
    .alu_fn (alu_fn),
    .dest   (dest),
    .ctrl   (ctrl_n),
    .waddr  (waddr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      ctrl_q  <= CTRL_FETCH;
      waddr_q <= '0;
    end else begin
      state_q <= state_n;
      ctrl_q  <= ctrl_n;
      waddr_q <= waddr_n;
    end
  end

  assign ir_ld    = ctrl_q.ir_ld;
  assign pc_ld    = ctrl_q.pc_ld;
  assign pc_sel   = ctrl_q.pc_sel;
  assign a_ld     = ctrl_q.a_ld;
  assign b_ld     = ctrl_q.b_ld;
  assign alu_op   = ctrl_q.alu_op;
  assign alu_bsel = ctrl_q.alu_bsel;
  assign r_ld     = ctrl_q.r_ld;
  assign mem_rd   = ctrl_q.mem_rd;
  assign mem_wr   = ctrl_q.mem_wr;
  assign wb_ld    = ctrl_q.wb_ld;
  assign wb_sel   = ctrl_q.wb_sel;
  assign rf_we    = ctrl_q.rf_we;
  assign rf_waddr = waddr_q;
  assign rf_dsel  = ctrl_q.rf_dsel;
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk #(
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           ir_ld,
  input logic           pc_ld,
  input logic [1:0]     pc_sel,
  input logic           a_ld,
  input logic           b_ld,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           rf_we,
  input logic [RAW-1:0] rf_waddr,
  input logic           rf_dsel
);
  a_r1_fetch_after_reset: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (ir_ld && pc_ld && pc_sel == 2'd0));

  a_r2_decode_follows_fetch: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (a_ld && b_ld && !ir_ld));

  a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_ld);

  a_r7_taken_then_fetch: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && pc_sel == 2'd1) |=> ir_ld);

  a_r9_link_then_jump: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_dsel) |=> (pc_ld && pc_sel == 2'd2));

  a_r11_no_write_r0: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != '0));

  a_r13_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mcyc_seq mcyc_seq_chk #(.RAW(RAW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ir_ld    (ir_ld),
  .pc_ld    (pc_ld),
  .pc_sel   (pc_sel),
  .a_ld     (a_ld),
  .b_ld     (b_ld),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .rf_we    (rf_we),
  .rf_waddr (rf_waddr),
  .rf_dsel  (rf_dsel)
);

// File: tb/mcyc_seq_test.sv
module mcyc_seq_test;
  localparam int IW = 32;
  localparam int RAW = 5;
  localparam int LNK = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] ir = '0;
  logic cond_r = 1'b0;

  logic ir_ld, pc_ld, a_ld, b_ld, alu_bsel, r_ld, mem_rd, mem_wr;
  logic wb_ld, wb_sel, rf_we, rf_dsel;
  logic [1:0] pc_sel;
  logic [2:0] alu_op;
  logic [RAW-1:0] rf_waddr;

  int vecs = 0;
  int bad = 0;
  bit done = 0;

  logic [IW-1:0] wq[$];
  logic          cq[$];
  logic [21:0]   eq[$];
  string         tq[$];

  always #10 clk = ~clk;

  mcyc_seq #(.IW(IW), .RAW(RAW), .LINK_REG(LNK)) uut (
    .clk(clk), .rst(rst), .instr(ir), .cond(cond_r),
    .ir_ld(ir_ld), .pc_ld(pc_ld), .pc_sel(pc_sel), .a_ld(a_ld), .b_ld(b_ld),
    .alu_op(alu_op), .alu_bsel(alu_bsel), .r_ld(r_ld), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wb_ld(wb_ld), .wb_sel(wb_sel), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_dsel(rf_dsel)
  );

  // Datapath instruction register model
  always @(posedge clk) begin
    if (!rst && ir_ld && wq.size() > 0) begin
      ir     <= wq.pop_front();
      cond_r <= cq.pop_front();
    end
  end

  function automatic logic [21:0] cv(input logic irl, pcl, input logic [1:0] ps,
      input logic al, bl, input logic [2:0] op, input logic bs, rl, mr, mw, wl, ws, we,
      input logic [4:0] wa, input logic ds);
    return {irl, pcl, ps, al, bl, op, bs, rl, mr, mw, wl, ws, we, wa, ds};
  endfunction

  function automatic logic [21:0] actual();
    return {ir_ld, pc_ld, pc_sel, a_ld, b_ld, alu_op, alu_bsel, r_ld, mem_rd, mem_wr,
            wb_ld, wb_sel, rf_we, rf_waddr, rf_dsel};
  endfunction

  localparam logic [21:0] V_FETCH = 22'b1_1_00_0_0_000_0_0_0_0_0_0_0_00000_0;
  localparam logic [21:0] V_DEC   = 22'b0_0_00_1_1_000_0_0_0_0_0_0_0_00000_0;
  localparam logic [21:0] V_NONE  = 22'd0;

  function automatic logic [21:0] v_write(input logic [4:0] d);
    return (d == 5'd0) ? V_NONE : cv(0,0,0,0,0,0,0,0,0,0,0,0,1,d,0);
  endfunction

  task automatic push(input logic [21:0] v, input string tag);
    eq.push_back(v);
    tq.push_back(tag);
  endtask

  // Driver: queue an instruction and its expected control words
  task automatic issue(input logic [31:0] w, input logic c);
    logic [5:0] op;
    logic [4:0] rt, rd;
    op = w[31:26]; rt = w[20:16]; rd = w[15:11];
    wq.push_back(w);
    cq.push_back(c);
    push(V_FETCH, "R2 fetch");
    push(V_DEC, "R2 decode");
    if (op == 6'h00) begin
      push(cv(0,0,0,0,0,w[2:0],0,1,0,0,0,0,0,0,0), "R3 exec");
      push(cv(0,0,0,0,0,0,0,0,0,0,1,0,0,0,0), "R3 wb");
      push(v_write(rd), (rd == 0) ? "R11 rr r0" : "R3 write");
    end else if (op[5:3] == 3'b001) begin
      push(cv(0,0,0,0,0,op[2:0],1,1,0,0,0,0,0,0,0), "R4 exec");
      push(cv(0,0,0,0,0,0,0,0,0,0,1,0,0,0,0), "R4 wb");
      push(v_write(rt), (rt == 0) ? "R11 ri r0" : "R4 write");
    end else if (op == 6'h23) begin
      push(cv(0,0,0,0,0,0,1,1,0,0,0,0,0,0,0), "R5 addr");
      push(cv(0,0,0,0,0,0,0,0,1,0,1,1,0,0,0), "R5 mem");
      push(v_write(rt), "R5 write");
    end else if (op == 6'h2B) begin
      push(cv(0,0,0,0,0,0,1,1,0,0,0,0,0,0,0), "R6 addr");
      push(cv(0,0,0,0,0,0,0,0,0,1,0,0,0,0,0), "R6 mem");
    end else if (op == 6'h04 || op == 6'h05) begin
      push(V_NONE, "R7 test");
      if ((op == 6'h04) ? c : !c)
        push(cv(0,1,1,0,0,0,0,0,0,0,0,0,0,0,0), "R7 taken");
    end else if (op == 6'h02) begin
      push(cv(0,1,2,0,0,0,0,0,0,0,0,0,0,0,0), "R8 jump");
    end else if (op == 6'h03) begin
      push(cv(0,0,0,0,0,0,0,0,0,0,0,0,1,5'(LNK),1), "R9 link");
      push(cv(0,1,2,0,0,0,0,0,0,0,0,0,0,0,0), "R9 jump");
    end else if (op == 6'h06) begin
      push(cv(0,1,3,0,0,0,0,0,0,0,0,0,0,0,0), "R10 jreg");
    end
    // R12: other opcodes go straight back to fetch
  endtask

  function automatic logic [31:0] rr(input logic [4:0] s, t, d, input logic [2:0] f);
    return {6'h00, s, t, d, 8'd0, f};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] o, input logic [4:0] s, t,
                                     input logic [15:0] imm);
    return {o, s, t, imm};
  endfunction

  task automatic check(input logic [21:0] exp, input string tag);
    logic [21:0] act;
    act = actual();
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (8000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // Program build, reset and monitor
  initial begin
    issue(rr(5'd1, 5'd2, 5'd3, 3'd0), 0);           // R3 add
    issue(rr(5'd4, 5'd5, 5'd31, 3'd6), 0);          // R3 sll to r31
    issue(rr(5'd1, 5'd2, 5'd0, 3'd1), 0);           // R11 rd=0
    issue(ri(6'h0D, 5'd1, 5'd7, 16'hFFF0), 0);      // R4 slt-imm
    issue(ri(6'h0B, 5'd2, 5'd0, 16'h0001), 0);      // R11 rt=0
    issue(ri(6'h23, 5'd6, 5'd4, 16'h0010), 0);      // R5 load
    issue(ri(6'h2B, 5'd6, 5'd4, 16'h0020), 1);      // R6 store
    issue(ri(6'h04, 5'd1, 5'd0, 16'h0008), 1);      // R7 bz taken
    issue(ri(6'h04, 5'd1, 5'd0, 16'h0008), 0);      // R7 bz not
    issue(ri(6'h05, 5'd1, 5'd0, 16'hFFFC), 0);      // R7 bnz taken
    issue(ri(6'h05, 5'd1, 5'd0, 16'hFFFC), 1);      // R7 bnz not
    issue({6'h02, 26'h0000040}, 0);                 // R8
    issue({6'h03, 26'h0000100}, 0);                 // R9
    issue(ri(6'h06, 5'd9, 5'd0, 16'h0000), 0);      // R10
    issue({6'h3F, 26'h3FFFFFF}, 1);                 // R12
    issue(ri(6'h08, 5'd3, 5'd12, 16'h0004), 0);     // R4 add-imm after bad
    push(V_FETCH, "R2 final fetch");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(V_FETCH, "R1 during reset");
    @(posedge clk);
    #1 rst = 1'b0;
    while (eq.size() > 0) begin
      logic [21:0] e;
      string t;
      @(negedge clk);
      e = eq.pop_front();
      t = tq.pop_front();
      check(e, t);
      if (mem_rd && mem_wr) begin
        bad++;
        $display("FAIL R13: actual rd=1 wr=1 expected exclusive");
      end
    end
    summary();
  end
endmodule